// File: doc/BRIEF.md
# Card Presence Debounce Event Generator

This block watches the active-low detect line of a removable card slot. A low level on the line means a card is seated. The raw line first passes through a two-stage synchroniser. The block then drives a steady `present` level and reports insertion and extraction as single-cycle pulses, but only once the line has stopped moving.

Each qualifying transition of the synchronised line starts a one-shot stability window, and a later transition restarts it. When the window runs out, the block reads the current level once. A present level gives an insertion pulse and an absent level gives an extraction pulse. The `fall_only` input selects which transitions count:

- With `fall_only` set, only a high-to-low transition (insertion) starts the window.
- With `fall_only` clear, both directions start it.

The window length defaults to 300 ms. It is given as a clock frequency and a duration in milliseconds, and the cycle count is derived from the two.

The controlling state machine has three states:

- `ST_IDLE`: nothing pending. A qualifying transition (`arm`) moves to `ST_WAIT`.
- `ST_WAIT`: window counting. Here `arm` reloads the window and stays in the state, and expiry with no `arm` moves to `ST_EMIT`.
- `ST_EMIT`: one cycle that drives the event pulse. It returns to `ST_IDLE`, or goes to `ST_WAIT` if `arm` is raised in the same cycle.

Top module: `presence_debounce`

## Requirements
- R1: `present` equals the inverse of `cd_n_raw` delayed by two clock edges (two-flop synchroniser); low on the line gives `present` = 1.
- R2: A high-to-low transition of the synchronised line starts the window in either mode. If nothing else happens, the event pulse can be sampled after the W+3rd rising edge that follows the raw change, where W = CLK_HZ/1000*WINDOW_MS cycles.
- R3: A low-to-high transition starts the window only when `fall_only` = 0. When `fall_only` = 1 it has no effect on the window or the events.
- R4: A qualifying transition while a window is in progress discards that window and starts a full new one. No event is emitted for the discarded window.
- R5: At expiry, a low synchronised line (card present) gives `ev_insert`, and a high line gives `ev_extract`.
- R6: Event pulses last exactly one cycle. `ev_insert` and `ev_extract` are never high together, and each expiry produces exactly one pulse.
- R7: After reset, `present` = 0 and no event is produced until the first qualifying transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cd_n_raw | input | 1 | Raw active-low card-detect line, asynchronous |
| fall_only | input | 1 | 1: only insertion transitions start the window; 0: both directions do |
| present | output | 1 | Synchronised card-present level |
| ev_insert | output | 1 | One-cycle insertion event pulse |
| ev_extract | output | 1 | One-cycle extraction event pulse |

## Verification
The bench measures the exact latency from a line change to its event pulse. An off-by-one in the counter or the synchroniser would show up as a shifted pulse.

It then bounces the line mid-window in both-edges mode. A design that fails to restart the window would report early, or would report the level that was held briefly. In insertion-only mode, a quick release after insertion must not re-arm the window. The bench expects an extraction at the original deadline, so a design that re-arms or latches the level at the edge fails.

It also holds the line still after reset to catch spurious start-up events, and it counts pulses in each window to catch stretched or doubled events.

// File: rtl/pd_pkg.sv
package pd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_EMIT = 2'd2
    } pd_state_e;
endpackage

// File: rtl/pd_sync.sv
module pd_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RESET_VAL;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= RESET_VAL;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pd_edge_qual.sv
module pd_edge_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic line_sync,
    input  logic fall_only,
    output logic arm
);
    logic line_q;
    logic fell;
    logic rose;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= 1'b1;
        else        line_q <= line_sync;
    end

    assign fell = line_q & ~line_sync;
    assign rose = ~line_q & line_sync;
    assign arm  = fell | (rose & ~fall_only);
endmodule

// File: rtl/pd_window_timer.sv
module pd_window_timer #(
    parameter int unsigned WIN_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW = $clog2(WIN_CYC + 1);
    localparam logic [CW-1:0] RELOAD = CW'(WIN_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt <= '0;
        else if (load)                 cnt <= RELOAD;
        else if (run && cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/presence_debounce.sv
module presence_debounce
    import pd_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 125_000_000,
    parameter int unsigned WINDOW_MS   = 300,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cd_n_raw,
    input  logic fall_only,
    output logic present,
    output logic ev_insert,
    output logic ev_extract
);
    localparam int unsigned WIN_CYC = (CLK_HZ / 1000) * WINDOW_MS;

    logic      line_sync;
    logic      arm;
    logic      expired;
    pd_state_e state_q, state_d;

    pd_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (cd_n_raw),
        .q_sync  (line_sync)
    );

    pd_edge_qual edge_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_sync (line_sync),
        .fall_only (fall_only),
        .arm       (arm)
    );

    pd_window_timer #(.WIN_CYC(WIN_CYC)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (arm),
        .run     (state_q == ST_WAIT),
        .expired (expired)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (arm) state_d = ST_WAIT;
            ST_WAIT: begin
                if (arm)          state_d = ST_WAIT;
                else if (expired) state_d = ST_EMIT;
            end
            ST_EMIT: state_d = arm ? ST_WAIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        present    = ~line_sync;
        ev_insert  = 1'b0;
        ev_extract = 1'b0;
        unique case (state_q)
            ST_EMIT: begin
                ev_insert  = ~line_sync;
                ev_extract = line_sync;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pd_checker.sv
module pd_checker (
    input logic clk,
    input logic rst_n,
    input logic cd_n_raw,
    input logic present,
    input logic ev_insert,
    input logic ev_extract
);
    logic [1:0] age;
    logic       seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age  <= '0;
            seen <= 1'b0;
        end else begin
            if (age != 2'd3) age <= age + 1'b1;
            if ((age == 2'd0 && !cd_n_raw) ||
                (age != 2'd0 && cd_n_raw != $past(cd_n_raw)))
                seen <= 1'b1;
        end
    end

    p_sync_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2) |-> (present == !$past(cd_n_raw, 2)));

    p_ext_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_extract |-> !present);

    p_ins_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_insert |-> present);

    p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_insert && ev_extract));

    p_ins_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_insert |=> !ev_insert);

    p_ext_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_extract |=> !ev_extract);

    p_quiet_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !seen |-> !(ev_insert || ev_extract));
endmodule

bind presence_debounce pd_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cd_n_raw   (cd_n_raw),
    .present    (present),
    .ev_insert  (ev_insert),
    .ev_extract (ev_extract)
);

// File: tb/presence_debounce_tb.sv
module presence_debounce_tb_top;
    localparam int W   = 20;
    localparam int LAT = W + 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cd_n_raw = 1'b1;
    logic fall_only = 1'b0;
    logic present, ev_insert, ev_extract;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    presence_debounce #(.CLK_HZ(20_000), .WINDOW_MS(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .cd_n_raw(cd_n_raw), .fall_only(fall_only),
        .present(present), .ev_insert(ev_insert), .ev_extract(ev_extract)
    );

    typedef struct packed {
        logic mode;
        logic lvl;
        logic e_ins;
        logic e_ext;
    } vec_t;

    localparam vec_t VEC [7] = '{
        '{1'b0, 1'b0, 1'b1, 1'b0},
        '{1'b0, 1'b1, 1'b0, 1'b1},
        '{1'b1, 1'b0, 1'b1, 1'b0},
        '{1'b1, 1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b1, 1'b0, 1'b0},
        '{1'b0, 1'b0, 1'b1, 1'b0},
        '{1'b0, 1'b1, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // counts n negedges from now; reports first pulse and pulse count
    task automatic watch(input int n, output int lat, output int ins,
                         output int ext, output int pulses);
        lat = 0; ins = 0; ext = 0; pulses = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (ev_insert || ev_extract) begin
                pulses++;
                if (lat == 0) begin
                    lat = i;
                    ins = int'(ev_insert);
                    ext = int'(ev_extract);
                end
            end
        end
    endtask

    initial begin
        #(8 * 200_000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int lat, ins, ext, pl;
        repeat (3) @(negedge clk);
        chk("R7 present during reset", int'(present), 0);
        rst_n = 1'b1;
        watch(3 * W, lat, ins, ext, pl);
        chk("R7 no event after reset", pl, 0);
        chk("R7 present after reset", int'(present), 0);

        // R1 synchroniser latency
        cd_n_raw = 1'b0;
        @(negedge clk);
        chk("R1 present after 1 edge", int'(present), 0);
        @(negedge clk);
        chk("R1 present after 2 edges", int'(present), 1);
        watch(3 * W, lat, ins, ext, pl);
        chk("R2 latency from insertion", lat, LAT - 2);
        chk("R5 insert type", ins, 1);
        chk("R6 single pulse", pl, 1);
        cd_n_raw = 1'b1;
        watch(3 * W, lat, ins, ext, pl);
        chk("R5 extract type", ext, 1);

        // vector table
        foreach (VEC[k]) begin
            fall_only = VEC[k].mode;
            cd_n_raw  = VEC[k].lvl;
            watch(3 * W, lat, ins, ext, pl);
            if (VEC[k].e_ins || VEC[k].e_ext) begin
                chk("R2 R3 vector latency", lat, LAT);
                chk("R5 vector insert", ins, int'(VEC[k].e_ins));
                chk("R5 vector extract", ext, int'(VEC[k].e_ext));
                chk("R6 vector pulses", pl, 1);
            end else begin
                chk("R3 vector no event", pl, 0);
            end
            chk("R1 vector present", int'(present), int'(!VEC[k].lvl));
        end

        // R4 retrigger in both-edges mode: short insertion bounce
        fall_only = 1'b0;
        cd_n_raw  = 1'b0;
        watch(10, lat, ins, ext, pl);
        chk("R4 no event during bounce", pl, 0);
        cd_n_raw = 1'b1;
        watch(3 * W, lat, ins, ext, pl);
        chk("R4 restarted latency", lat, LAT);
        chk("R4 extract after bounce", ext, 1);
        chk("R6 one pulse after bounce", pl, 1);

        // R3 insertion-only mode: release does not re-arm
        fall_only = 1'b1;
        cd_n_raw  = 1'b0;
        watch(5, lat, ins, ext, pl);
        chk("R3 no early event", pl, 0);
        cd_n_raw = 1'b1;
        watch(3 * W, lat, ins, ext, pl);
        chk("R3 original deadline kept", lat, LAT - 5);
        chk("R5 level read at expiry", ext, 1);
        chk("R6 one pulse insertion-only", pl, 1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule